// File: doc/BRIEF.md
# Host Register Frame Buffer

This block sits between a host register bus and a minimal network port. It keeps one received frame and one outgoing frame, each in a byte store sized for the largest Ethernet frame (1514 bytes). The host empties the received frame one byte per register read from a single data port. It fills the outgoing frame one byte per register write to another single data port. Once the host has written as many bytes as it declared, the frame streams out by itself.

The interrupt and status logic is a neighbouring block. It drives the `busy_i` input and consumes the one-cycle `rx_done_o` and `tx_done_o` event pulses. It also owns the interrupt control and interrupt info offsets, so this block returns zero for reads there. Incoming bytes arrive on a valid/data/last stream gated by `rx_ready_o`. Outgoing bytes leave on a valid/data/last stream at one byte per clock.

Top module: `frame_regif`

## Requirements
- R1: After reset, every count and pointer is 0. `tx_valid_o`, `rx_done_o`, `tx_done_o` and `reg_rdata_o` are 0.
- R2: Offset 0x00 reads the parameter `ID_WORD0`, and offset 0x04 reads `ID_WORD1`. Offset 0x08 reads `busy_i` in bit 0, with all other bits 0.
- R3: `rx_ready_o` is high while a frame is partly received. Between frames it is high only when `busy_i` is 0 and the stored receive count is below 1514. Otherwise it is low, and input bytes are not taken.
- R4: A frame is taken on each beat where `rx_valid_i` and `rx_ready_o` are both high. Its bytes are stored from index 0, and bytes past 1514 are dropped. On the beat with `rx_last_i`, the receive count (offset 0x0C) becomes the stored length, capped at 1514, and the read pointer returns to 0. `rx_done_o` pulses for the one cycle after that beat.
- R5: A read of offset 0x1C with a nonzero receive count returns the byte at the read pointer in bits 7:0. It also advances the pointer and lowers the count by one. With a zero count, the read returns 0 and changes nothing.
- R6: A write to offset 0x10 loads the transmit count with the value if it is at most 1514, and with 0 otherwise. It also clears the written-byte index. Offset 0x10 reads back the transmit count.
- R7: A write to offset 0x20 stores bits 7:0 at the written index and advances the index. When the index reaches the transmit count, that count and the index are cleared. In the cycle after that write, `tx_done_o` pulses and streaming begins.
- R8: The frame leaves on `tx_data_o` one byte per clock, in written order, with `tx_valid_o` high. `tx_last_o` is high on the final byte only.
- R9: Writes to offset 0x20 are ignored while a frame is streaming, or while the transmit count is 0.
- R10: Writes to 0x00, 0x04, 0x08, 0x0C, 0x14, 0x18, 0x1C and unmapped offsets change nothing. Reads of 0x14, 0x18, 0x20 and unmapped offsets return 0.
- R11: Read data is registered. It appears on `reg_rdata_o` in the cycle after the `reg_rd_i` strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr_i | input | 6 | Register offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| busy_i | input | 1 | Busy flag from the status block |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_data_i | input | 8 | Incoming byte |
| rx_last_i | input | 1 | Final byte of incoming frame |
| rx_ready_o | output | 1 | Incoming byte accepted this cycle |
| rx_done_o | output | 1 | Frame-received event pulse |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_data_o | output | 8 | Outgoing byte |
| tx_last_o | output | 1 | Final byte of outgoing frame |
| tx_done_o | output | 1 | Frame-sent event pulse |

## Verification
- **Register reads:** Every register read returns its data one clock after the strobe edge. Each read task therefore raises the strobe at a falling edge and samples at the next falling edge.
- **Receive completion:** `rx_done_o` and the new receive count are due one edge after the beat that carries `rx_last_i`. The bench samples them at the falling edge right after that beat.
- **Transmit start:** `tx_done_o` and the first outgoing byte are due together one edge after the completing data write. Later bytes follow one per clock. A falling-edge monitor records each byte with its last flag, and the tasks compare the recorded frame once `tx_valid_o` has fallen.
- **Refused input:** Input offered while `rx_ready_o` is low is checked through the receive count and the event pulses seen afterwards.

// File: rtl/fb_pkg.sv
`timescale 1ns/1ps
package fb_pkg;
    localparam int unsigned REG_AW = 6;
    localparam int unsigned REG_DW = 32;

    typedef enum logic [REG_AW-1:0] {
        OFF_ID0     = 6'h00,
        OFF_ID1     = 6'h04,
        OFF_BUSY    = 6'h08,
        OFF_RXCNT   = 6'h0C,
        OFF_TXCNT   = 6'h10,
        OFF_IRQCTL  = 6'h14,
        OFF_IRQINFO = 6'h18,
        OFF_RXDATA  = 6'h1C,
        OFF_TXDATA  = 6'h20
    } fb_off_e;
endpackage

// File: rtl/fb_byte_buf.sv
`timescale 1ns/1ps
module fb_byte_buf #(
    parameter int unsigned DEPTH = 1514,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fb_rx_ctrl.sv
`timescale 1ns/1ps
module fb_rx_ctrl #(
    parameter int unsigned MAX_LEN = 1514,
    parameter int unsigned CW      = $clog2(MAX_LEN + 1),
    parameter int unsigned AW      = $clog2(MAX_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    input  logic          pop,
    output logic [7:0]    pop_byte,
    output logic [CW-1:0] count_o,
    output logic          done_o
);
    localparam logic [CW-1:0] MAXC = CW'(MAX_LEN);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] wr_idx;
        logic [CW-1:0] count;
        logic [AW-1:0] rd_ptr;
        logic          done;
    } rx_st_t;

    rx_st_t     st_d, st_q;
    logic       beat;
    logic       room;
    logic [7:0] buf_rd;

    assign in_ready = st_q.active || (!busy_i && (st_q.count < MAXC));
    assign beat     = in_valid && in_ready;
    assign room     = st_q.wr_idx < MAXC;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (pop && (st_q.count != '0)) begin
            st_d.rd_ptr = st_q.rd_ptr + AW'(1);
            st_d.count  = st_q.count - ONE;
        end
        if (beat) begin
            if (room) begin
                st_d.wr_idx = st_q.wr_idx + ONE;
            end
            if (in_last) begin
                st_d.active = 1'b0;
                st_d.count  = room ? (st_q.wr_idx + ONE) : MAXC;
                st_d.rd_ptr = '0;
                st_d.wr_idx = '0;
                st_d.done   = 1'b1;
            end else begin
                st_d.active = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fb_byte_buf #(.DEPTH(MAX_LEN), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (beat && room),
        .waddr (AW'(st_q.wr_idx)),
        .wdata (in_data),
        .raddr (st_q.rd_ptr),
        .rdata (buf_rd)
    );

    assign pop_byte = (st_q.count != '0) ? buf_rd : 8'h00;
    assign count_o  = st_q.count;
    assign done_o   = st_q.done;
endmodule

// File: rtl/fb_tx_ctrl.sv
`timescale 1ns/1ps
module fb_tx_ctrl #(
    parameter int unsigned MAX_LEN = 1514,
    parameter int unsigned CW      = $clog2(MAX_LEN + 1),
    parameter int unsigned AW      = $clog2(MAX_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          len_we,
    input  logic [31:0]   len_val,
    input  logic          data_we,
    input  logic [7:0]    data_byte,
    output logic [CW-1:0] count_o,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_last,
    output logic          done_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] count;
        logic [CW-1:0] idx;
        logic          streaming;
        logic [CW-1:0] s_len;
        logic [CW-1:0] s_idx;
        logic          done;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   wr_ok;
    logic   at_end;

    assign at_end = st_q.s_idx == (st_q.s_len - ONE);
    assign wr_ok  = data_we && !st_q.streaming && (st_q.count != '0);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.streaming) begin
            if (at_end) begin
                st_d.streaming = 1'b0;
            end else begin
                st_d.s_idx = st_q.s_idx + ONE;
            end
        end
        if (len_we) begin
            st_d.count = (len_val <= 32'(MAX_LEN)) ? CW'(len_val) : '0;
            st_d.idx   = '0;
        end
        if (wr_ok) begin
            if ((st_q.idx + ONE) == st_q.count) begin
                st_d.count     = '0;
                st_d.idx       = '0;
                st_d.streaming = 1'b1;
                st_d.s_len     = st_q.count;
                st_d.s_idx     = '0;
                st_d.done      = 1'b1;
            end else begin
                st_d.idx = st_q.idx + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fb_byte_buf #(.DEPTH(MAX_LEN), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (AW'(st_q.idx)),
        .wdata (data_byte),
        .raddr (AW'(st_q.s_idx)),
        .rdata (out_data)
    );

    assign count_o   = st_q.count;
    assign out_valid = st_q.streaming;
    assign out_last  = st_q.streaming && at_end;
    assign done_o    = st_q.done;
endmodule

// File: rtl/frame_regif.sv
`timescale 1ns/1ps
module frame_regif #(
    parameter int unsigned MAX_LEN  = 1514,
    parameter logic [31:0] ID_WORD0 = 32'h4652_4246,
    parameter logic [31:0] ID_WORD1 = 32'h0000_0101,
    parameter int unsigned CW       = $clog2(MAX_LEN + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  reg_addr_i,
    input  logic        reg_wr_i,
    input  logic        reg_rd_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    input  logic        busy_i,
    input  logic        rx_valid_i,
    input  logic [7:0]  rx_data_i,
    input  logic        rx_last_i,
    output logic        rx_ready_o,
    output logic        rx_done_o,
    output logic        tx_valid_o,
    output logic [7:0]  tx_data_o,
    output logic        tx_last_o,
    output logic        tx_done_o
);
    import fb_pkg::*;

    typedef struct packed {
        logic [REG_DW-1:0] rdata;
    } top_st_t;

    top_st_t       st_d, st_q;
    logic [CW-1:0] rx_cnt;
    logic [CW-1:0] tx_cnt;
    logic [7:0]    rx_byte;
    logic          rx_pop;
    logic          tx_len_we;
    logic          tx_data_we;

    assign rx_pop     = reg_rd_i && (reg_addr_i == OFF_RXDATA);
    assign tx_len_we  = reg_wr_i && (reg_addr_i == OFF_TXCNT);
    assign tx_data_we = reg_wr_i && (reg_addr_i == OFF_TXDATA);

    always_comb begin
        st_d = st_q;
        if (reg_rd_i) begin
            case (reg_addr_i)
                OFF_ID0:    st_d.rdata = ID_WORD0;
                OFF_ID1:    st_d.rdata = ID_WORD1;
                OFF_BUSY:   st_d.rdata = {31'd0, busy_i};
                OFF_RXCNT:  st_d.rdata = 32'(rx_cnt);
                OFF_TXCNT:  st_d.rdata = 32'(tx_cnt);
                OFF_RXDATA: st_d.rdata = {24'd0, rx_byte};
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fb_rx_ctrl #(.MAX_LEN(MAX_LEN), .CW(CW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_i   (busy_i),
        .in_valid (rx_valid_i),
        .in_data  (rx_data_i),
        .in_last  (rx_last_i),
        .in_ready (rx_ready_o),
        .pop      (rx_pop),
        .pop_byte (rx_byte),
        .count_o  (rx_cnt),
        .done_o   (rx_done_o)
    );

    fb_tx_ctrl #(.MAX_LEN(MAX_LEN), .CW(CW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_we    (tx_len_we),
        .len_val   (reg_wdata_i),
        .data_we   (tx_data_we),
        .data_byte (reg_wdata_i[7:0]),
        .count_o   (tx_cnt),
        .out_valid (tx_valid_o),
        .out_data  (tx_data_o),
        .out_last  (tx_last_o),
        .done_o    (tx_done_o)
    );

    assign reg_rdata_o = st_q.rdata;
endmodule

// File: rtl/fb_regif_chk.sv
`timescale 1ns/1ps
module fb_regif_chk #(
    parameter int unsigned MAX_LEN = 1514,
    parameter int unsigned CW      = $clog2(MAX_LEN + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [5:0]    reg_addr_i,
    input logic          reg_rd_i,
    input logic [31:0]   reg_rdata_o,
    input logic          rx_valid_i,
    input logic          rx_last_i,
    input logic          rx_ready_o,
    input logic          rx_done_o,
    input logic          tx_valid_o,
    input logic          tx_last_o,
    input logic          tx_done_o,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_cnt
);
    assert_rx_cnt_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(MAX_LEN));

    assert_rx_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_o |-> $past(rx_valid_i && rx_ready_o && rx_last_i));

    assert_rx_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && (reg_addr_i == 6'h1C) && (rx_cnt == '0)) |=> (reg_rdata_o == 32'd0));

    assert_tx_cnt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(MAX_LEN));

    assert_tx_start_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid_o) |-> tx_done_o);

    assert_tx_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |=> !tx_done_o);

    assert_tx_last_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last_o |-> tx_valid_o);

    assert_tx_stream_gapless_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_last_o) |=> tx_valid_o);

    assert_tx_ends_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_valid_o) |-> $past(tx_last_o));
endmodule

bind frame_regif fb_regif_chk #(.MAX_LEN(MAX_LEN), .CW(CW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr_i  (reg_addr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_rdata_o (reg_rdata_o),
    .rx_valid_i  (rx_valid_i),
    .rx_last_i   (rx_last_i),
    .rx_ready_o  (rx_ready_o),
    .rx_done_o   (rx_done_o),
    .tx_valid_o  (tx_valid_o),
    .tx_last_o   (tx_last_o),
    .tx_done_o   (tx_done_o),
    .rx_cnt      (rx_cnt),
    .tx_cnt      (tx_cnt)
);

// File: tb/frame_regif_tb_top.sv
`timescale 1ns/1ps
module frame_regif_tb_top;
    localparam logic [31:0] ID0 = 32'h4652_4246;
    localparam logic [31:0] ID1 = 32'h0000_0101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_ready, rx_done, tx_valid, tx_last, tx_done;
    logic [7:0]  tx_data;

    int n_chk  = 0;
    int n_fail = 0;
    int rx_done_seen = 0;
    int tx_done_seen = 0;
    int cap_n = 0;
    int cap_lasts = 0;
    int cap_last_pos = -1;
    logic [7:0] cap [64];

    always #2.5 clk = ~clk;

    frame_regif dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
        .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .busy_i(busy), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .rx_last_i(rx_last), .rx_ready_o(rx_ready), .rx_done_o(rx_done),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
        .tx_done_o(tx_done)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_done) rx_done_seen++;
            if (tx_done) tx_done_seen++;
            if (tx_valid) begin
                if (cap_n < 64) cap[cap_n] = tx_data;
                if (tx_last) begin
                    cap_lasts++;
                    cap_last_pos = cap_n;
                end
                cap_n++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rx_send(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data = base + 8'(i);
            rx_last = (i == n - 1);
            while (!rx_ready) @(negedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last = 1'b0;
    endtask

    task automatic wait_tx_idle();
        while (tx_valid) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 rdata after reset", reg_rdata, 32'd0);
        chk("R1 tx_valid after reset", {31'd0, tx_valid}, 32'd0);
        chk("R1 rx_done after reset", {31'd0, rx_done}, 32'd0);
        chk("R1 tx_done after reset", {31'd0, tx_done}, 32'd0);
        chk("R3 ready low while busy", {31'd0, rx_ready}, 32'd0);
        bus_rd(6'h0C, d); chk("R1 rx count reset", d, 32'd0);
        bus_rd(6'h10, d); chk("R1 tx count reset", d, 32'd0);
    endtask

    task automatic t_ids();
        logic [31:0] d;
        bus_rd(6'h00, d); chk("R2 id word 0", d, ID0);
        bus_rd(6'h04, d); chk("R2 id word 1", d, ID1);
        bus_rd(6'h08, d); chk("R2 busy read 1", d, 32'd1);
        busy = 1'b0;
        bus_rd(6'h08, d); chk("R2 busy read 0", d, 32'd0);
        repeat (3) @(negedge clk);
        chk("R11 read data held", reg_rdata, 32'd0);
        bus_rd(6'h00, d);
        repeat (3) @(negedge clk);
        chk("R11 id held after idle", reg_rdata, ID0);
    endtask

    task automatic t_rx_small();
        logic [31:0] d;
        chk("R3 ready when idle and not busy", {31'd0, rx_ready}, 32'd1);
        rx_send(5, 8'h30);
        chk("R4 rx_done pulse", {31'd0, rx_done}, 32'd1);
        @(negedge clk);
        chk("R4 rx_done single cycle", {31'd0, rx_done}, 32'd0);
        bus_rd(6'h0C, d); chk("R4 rx count = length", d, 32'd5);
        for (int i = 0; i < 5; i++) begin
            bus_rd(6'h1C, d); chk("R5 rx byte", d, 32'h30 + 32'(i));
        end
        bus_rd(6'h0C, d); chk("R5 rx count drained", d, 32'd0);
        bus_rd(6'h1C, d); chk("R5 empty read zero", d, 32'd0);
        bus_rd(6'h0C, d); chk("R5 empty read no change", d, 32'd0);
    endtask

    task automatic t_rx_refused();
        logic [31:0] d;
        int seen;
        seen = rx_done_seen;
        @(negedge clk);
        busy = 1'b1;
        rx_valid = 1'b1;
        rx_last = 1'b1;
        rx_data = 8'h77;
        @(negedge clk);
        chk("R3 ready low when busy", {31'd0, rx_ready}, 32'd0);
        repeat (3) @(negedge clk);
        rx_valid = 1'b0;
        rx_last = 1'b0;
        @(negedge clk);
        chk("R3 refused frame no event", 32'(rx_done_seen - seen), 32'd0);
        bus_rd(6'h0C, d); chk("R3 refused frame no count", d, 32'd0);
        busy = 1'b0;
    endtask

    task automatic t_rx_oversize();
        logic [31:0] d;
        rx_send(1600, 8'h00);
        bus_rd(6'h0C, d); chk("R4 oversize count capped", d, 32'd1514);
        chk("R3 ready low when count full", {31'd0, rx_ready}, 32'd0);
        bus_rd(6'h1C, d); chk("R4 oversize first byte", d, 32'h00);
        chk("R3 ready back after drain", {31'd0, rx_ready}, 32'd1);
        for (int i = 1; i < 1513; i++) begin
            bus_rd(6'h1C, d);
        end
        bus_rd(6'h1C, d); chk("R4 last stored byte", d, 32'h000000E9);
        bus_rd(6'h0C, d); chk("R4 oversize fully drained", d, 32'd0);
    endtask

    task automatic t_tx_len();
        logic [31:0] d;
        bus_wr(6'h10, 32'd1515);
        bus_rd(6'h10, d); chk("R6 over-length loads 0", d, 32'd0);
        bus_wr(6'h10, 32'd1514);
        bus_rd(6'h10, d); chk("R6 max length loads", d, 32'd1514);
        bus_wr(6'h10, 32'd0);
        bus_rd(6'h10, d); chk("R6 zero length loads", d, 32'd0);
        cap_n = 0;
        bus_wr(6'h20, 32'h55);
        repeat (4) @(negedge clk);
        chk("R9 data write with zero count ignored", 32'(cap_n), 32'd0);
        bus_rd(6'h10, d); chk("R9 zero count unchanged", d, 32'd0);
    endtask

    task automatic t_tx_frame();
        logic [31:0] d;
        int seen;
        seen = tx_done_seen;
        cap_n = 0; cap_lasts = 0; cap_last_pos = -1;
        bus_wr(6'h10, 32'd4);
        for (int i = 0; i < 3; i++) begin
            bus_wr(6'h20, 32'hABCD_1200 | 32'(8'hA0 + 8'(i)));
        end
        chk("R7 no done before count reached", {31'd0, tx_done}, 32'd0);
        chk("R7 no stream before count reached", {31'd0, tx_valid}, 32'd0);
        bus_wr(6'h20, 32'hFFFF_FFA3);
        chk("R7 tx_done with final write", {31'd0, tx_done}, 32'd1);
        chk("R7 stream starts", {31'd0, tx_valid}, 32'd1);
        wait_tx_idle();
        chk("R7 single done pulse", 32'(tx_done_seen - seen), 32'd1);
        chk("R8 frame length", 32'(cap_n), 32'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R8 frame byte", {24'd0, cap[i]}, 32'(8'hA0 + 8'(i)));
        end
        chk("R8 one last flag", 32'(cap_lasts), 32'd1);
        chk("R8 last on final byte", 32'(cap_last_pos), 32'd3);
        bus_rd(6'h10, d); chk("R7 count cleared", d, 32'd0);
    endtask

    task automatic t_tx_ignored_while_streaming();
        logic [31:0] d;
        cap_n = 0; cap_lasts = 0;
        bus_wr(6'h10, 32'd20);
        for (int i = 0; i < 20; i++) begin
            bus_wr(6'h20, 32'(8'h40 + 8'(i)));
        end
        bus_wr(6'h10, 32'd2);
        bus_wr(6'h20, 32'hAA);
        chk("R9 still streaming during write", {31'd0, tx_valid}, 32'd1);
        wait_tx_idle();
        chk("R8 long frame length", 32'(cap_n), 32'd20);
        chk("R8 long frame byte 19", {24'd0, cap[19]}, 32'h53);
        bus_rd(6'h10, d); chk("R6 count loaded during stream", d, 32'd2);
        cap_n = 0;
        bus_wr(6'h20, 32'h11);
        bus_wr(6'h20, 32'h22);
        wait_tx_idle();
        chk("R9 frame length after ignored write", 32'(cap_n), 32'd2);
        chk("R9 first byte not the ignored one", {24'd0, cap[0]}, 32'h11);
        chk("R9 second byte", {24'd0, cap[1]}, 32'h22);
    endtask

    task automatic t_readonly_unmapped();
        logic [31:0] d;
        rx_send(2, 8'h90);
        bus_wr(6'h0C, 32'd9);
        bus_wr(6'h1C, 32'd9);
        bus_wr(6'h00, 32'd9);
        bus_wr(6'h3C, 32'd9);
        bus_rd(6'h0C, d); chk("R10 rx count write ignored", d, 32'd2);
        bus_rd(6'h00, d); chk("R10 id write ignored", d, ID0);
        bus_rd(6'h14, d); chk("R10 irq ctl reads 0", d, 32'd0);
        bus_rd(6'h18, d); chk("R10 irq info reads 0", d, 32'd0);
        bus_rd(6'h20, d); chk("R10 tx data reads 0", d, 32'd0);
        bus_rd(6'h24, d); chk("R10 unmapped reads 0", d, 32'd0);
        bus_rd(6'h1C, d); chk("R10 rx data intact", d, 32'h90);
        bus_rd(6'h1C, d); chk("R10 rx data intact 2", d, 32'h91);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ids();
        t_rx_small();
        t_rx_refused();
        t_rx_oversize();
        t_tx_len();
        t_tx_frame();
        t_tx_ignored_while_streaming();
        t_readonly_unmapped();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule